// File: doc/BRIEF.md
# XGMII inter-frame gap checker

This block observes a 64-bit, eight-lane XGMII byte stream, either the transmit or the receive side of a 10G link. It measures the number of byte times that separate consecutive frames. At every frame start it compares the measured gap with a configured minimum and raises a one-cycle violation pulse when the gap is not acceptable. It also reports the measured gap and keeps a running count of frame starts. Frame contents are not examined.

The minimum is a parameter. A transmitter is usually held to 12 bytes. A receiver that allows for gap shrinkage is usually held to 5 bytes, with deficit tolerance switched off. When deficit tolerance is enabled, an individual gap may fall below the minimum. The shortfall is stored in a small deficit, and the gap is accepted as long as that deficit stays within 3 bytes. Gaps longer than the minimum pay the deficit back.

Top module: `xgmii_ifg_monitor`

## Requirements
- R1: After reset, `gap_o`, `gap_valid_o`, `viol_o` and `frame_cnt_o` are all zero, and the internal gap count starts at 15. A frame that starts immediately after reset therefore reports a gap of 15 and is compliant.
- R2: Lane n uses control bit n and data bits [8n+7:8n]. A lane whose control bit is set is decoded by its byte: 0xFB is a start, 0xFD is a terminate and 0x07 is an idle. Lanes are examined in order from 0 to 7, so a gap can cross word boundaries, and a start may appear in any lane.
- R3: A terminate seen inside a frame sets the gap count to 1. Each idle lane outside a frame adds 1. When a start arrives outside a frame, the count reached at that point is reported on `gap_o`, and `gap_valid_o` pulses in the cycle after the word that carried the start.
- R4: With deficit tolerance off (`DIC_EN`=0), a gap shorter than `MIN_GAP` asserts `viol_o`. A gap equal to `MIN_GAP` does not.
- R5: With deficit tolerance on, the shortfall of a gap below `MIN_GAP` is added to the deficit. `viol_o` asserts when the sum exceeds 3. The deficit is then held at 3.
- R6: With deficit tolerance on, a gap longer than `MIN_GAP` subtracts the excess from the deficit. The deficit does not go below 0.
- R7: The gap count saturates at 255 and does not wrap.
- R8: A terminate outside a frame is ignored and is not counted. A start inside a frame is ignored: it is neither checked nor counted. Idle lanes inside a frame do not add to the gap.
- R9: `frame_cnt_o` adds 1 for each accepted start, including several starts in one word. In that case `gap_o` shows the gap of the last start, and `viol_o` is set if any of those starts violated.
- R10: `gap_o` and `frame_cnt_o` hold their values between starts, and `viol_o` only asserts together with `gap_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xgmii_ctl_i | input | 8 | Per-lane control flags |
| xgmii_data_i | input | 64 | Eight lane bytes, lane 0 in the low byte |
| gap_o | output | 8 | Gap measured at the most recent start |
| gap_valid_o | output | 1 | One-cycle pulse when a start was checked |
| viol_o | output | 1 | One-cycle pulse on a gap violation |
| frame_cnt_o | output | 16 | Count of accepted frame starts, wrapping |

## Verification
Two instances run side by side on the same byte stream: one is a strict receiver checker with a 5-byte minimum, the other a transmit checker with a 12-byte minimum and deficit tolerance. The stream carries gaps exactly at the minimum, one byte under it and well under it. This separates a correct comparison from an off-by-one. A run of short gaps drives the deficit to its limit and then one byte past it, and long gaps then pay it back. Together these distinguish a correct accumulate, clamp and floor from a deficit that wraps or never recovers. Very long idle runs, stray terminates, starts inside frames, and back-to-back minimal frames that place several starts in one word test saturation, the ignore rules and per-word aggregation.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;

  typedef enum logic [2:0] {
    K_DATA,
    K_IDLE,
    K_START,
    K_TERM,
    K_CTRL_OTHER
  } lane_kind_e;

endpackage

// File: rtl/ifg_lane_class.sv
module ifg_lane_class
  import ifg_pkg::*;
(
  input  logic       ctl_i,
  input  logic [7:0] byte_i,
  output lane_kind_e kind_o
);

  always_comb begin
    if (!ctl_i)                 kind_o = K_DATA;
    else if (byte_i == CH_IDLE)  kind_o = K_IDLE;
    else if (byte_i == CH_START) kind_o = K_START;
    else if (byte_i == CH_TERM)  kind_o = K_TERM;
    else                         kind_o = K_CTRL_OTHER;
  end

endmodule

// File: rtl/ifg_lane_step.sv
module ifg_lane_step
  import ifg_pkg::*;
#(
  parameter int GAP_W   = 8,
  parameter int DEF_W   = 2,
  parameter int MIN_GAP = 12,
  parameter int DEF_MAX = 3,
  parameter bit DIC_EN  = 1'b1
) (
  input  lane_kind_e       kind_i,
  input  logic             in_frame_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [DEF_W-1:0] def_i,
  output logic             in_frame_o,
  output logic [GAP_W-1:0] gap_o,
  output logic [DEF_W-1:0] def_o,
  output logic             start_o,
  output logic             viol_o
);

  localparam int SW = GAP_W + DEF_W + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [SW-1:0] MIN_X  = SW'(MIN_GAP);
  localparam logic [SW-1:0] DMAX_X = SW'(DEF_MAX);

  logic [SW-1:0]    gap_x, def_x;
  logic [DEF_W-1:0] def_chk;
  logic             viol_chk;

  assign gap_x = SW'(gap_i);
  assign def_x = SW'(def_i);

  generate
    if (DIC_EN) begin : g_dic
      logic [SW-1:0] sum_x, exc_x;
      always_comb begin
        sum_x    = def_x + (MIN_X - gap_x);
        exc_x    = gap_x - MIN_X;
        def_chk  = def_i;
        viol_chk = 1'b0;
        if (gap_x < MIN_X) begin
          if (sum_x > DMAX_X) begin
            viol_chk = 1'b1;
            def_chk  = DEF_W'(DEF_MAX);
          end else begin
            def_chk  = DEF_W'(sum_x);
          end
        end else if (gap_x > MIN_X) begin
          def_chk = (exc_x >= def_x) ? '0 : DEF_W'(def_x - exc_x);
        end
      end
    end else begin : g_strict
      assign def_chk  = def_i;
      assign viol_chk = (gap_x < MIN_X);
    end
  endgenerate

  always_comb begin
    in_frame_o = in_frame_i;
    gap_o      = gap_i;
    def_o      = def_i;
    start_o    = 1'b0;
    viol_o     = 1'b0;
    unique case (kind_i)
      K_IDLE: begin
        if (!in_frame_i && gap_i != GAP_MAX) gap_o = gap_i + 1'b1;
      end
      K_TERM: begin
        if (in_frame_i) begin
          in_frame_o = 1'b0;
          gap_o      = GAP_W'(1);
        end
      end
      K_START: begin
        if (!in_frame_i) begin
          in_frame_o = 1'b1;
          gap_o      = '0;
          def_o      = def_chk;
          start_o    = 1'b1;
          viol_o     = viol_chk;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xgmii_ifg_monitor.sv
module xgmii_ifg_monitor
  import ifg_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int GAP_W    = 8,
  parameter int MIN_GAP  = 12,
  parameter int DEF_MAX  = 3,
  parameter bit DIC_EN   = 1'b1,
  parameter int GAP_INIT = 15,
  parameter int CNT_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   xgmii_ctl_i,
  input  logic [LANES*8-1:0] xgmii_data_i,
  output logic [GAP_W-1:0]   gap_o,
  output logic               gap_valid_o,
  output logic               viol_o,
  output logic [CNT_W-1:0]   frame_cnt_o
);

  localparam int DEF_W = (DEF_MAX > 0) ? $clog2(DEF_MAX + 1) : 1;
  localparam int SC_W  = $clog2(LANES + 1);

  logic             in_frame_q;
  logic [GAP_W-1:0] gap_q;
  logic [DEF_W-1:0] def_q;

  logic [LANES:0]   fr_c;
  logic [GAP_W-1:0] gap_c [LANES+1];
  logic [DEF_W-1:0] def_c [LANES+1];
  logic [LANES-1:0] start_v, viol_v;
  logic [GAP_W-1:0] meas_gap;
  logic [SC_W-1:0]  n_start;

  assign fr_c[0]  = in_frame_q;
  assign gap_c[0] = gap_q;
  assign def_c[0] = def_q;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_kind_e kind;
      ifg_lane_class i_class (
        .ctl_i  (xgmii_ctl_i[l]),
        .byte_i (xgmii_data_i[8*l +: 8]),
        .kind_o (kind)
      );
      ifg_lane_step #(
        .GAP_W   (GAP_W),
        .DEF_W   (DEF_W),
        .MIN_GAP (MIN_GAP),
        .DEF_MAX (DEF_MAX),
        .DIC_EN  (DIC_EN)
      ) i_step (
        .kind_i     (kind),
        .in_frame_i (fr_c[l]),
        .gap_i      (gap_c[l]),
        .def_i      (def_c[l]),
        .in_frame_o (fr_c[l+1]),
        .gap_o      (gap_c[l+1]),
        .def_o      (def_c[l+1]),
        .start_o    (start_v[l]),
        .viol_o     (viol_v[l])
      );
    end
  endgenerate

  // last start in the word wins
  always_comb begin
    meas_gap = gap_o;
    for (int l = 0; l < LANES; l++) begin
      if (start_v[l]) meas_gap = gap_c[l];
    end
  end

  assign n_start = SC_W'($countones(start_v));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      gap_q       <= GAP_W'(GAP_INIT);
      def_q       <= '0;
      gap_o       <= '0;
      gap_valid_o <= 1'b0;
      viol_o      <= 1'b0;
      frame_cnt_o <= '0;
    end else begin
      in_frame_q  <= fr_c[LANES];
      gap_q       <= gap_c[LANES];
      def_q       <= def_c[LANES];
      gap_o       <= meas_gap;
      gap_valid_o <= |start_v;
      viol_o      <= |viol_v;
      frame_cnt_o <= frame_cnt_o + CNT_W'(n_start);
    end
  end

endmodule

// File: rtl/xgmii_ifg_monitor_chk.sv
module xgmii_ifg_monitor_chk #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 12,
  parameter int DEF_MAX = 3,
  parameter bit DIC_EN  = 1'b1,
  parameter int CNT_W   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [GAP_W-1:0] gap_o,
  input logic             gap_valid_o,
  input logic             viol_o,
  input logic [CNT_W-1:0] frame_cnt_o
);

  p_viol_at_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> gap_valid_o);

  p_gap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gap_valid_o |-> $stable(gap_o));

  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gap_valid_o |-> $stable(frame_cnt_o));

  p_cnt_moves_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_valid_o |-> frame_cnt_o != $past(frame_cnt_o));

  generate
    if (!DIC_EN) begin : g_strict
      p_short_viol_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gap_valid_o && int'(gap_o) < MIN_GAP) |-> viol_o);
    end else if (MIN_GAP > DEF_MAX) begin : g_dic
      p_deep_short_viol_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gap_valid_o && int'(gap_o) < MIN_GAP - DEF_MAX) |-> viol_o);
    end
  endgenerate

endmodule

bind xgmii_ifg_monitor xgmii_ifg_monitor_chk #(
  .GAP_W   (GAP_W),
  .MIN_GAP (MIN_GAP),
  .DEF_MAX (DEF_MAX),
  .DIC_EN  (DIC_EN),
  .CNT_W   (CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gap_o       (gap_o),
  .gap_valid_o (gap_valid_o),
  .viol_o      (viol_o),
  .frame_cnt_o (frame_cnt_o)
);

// File: tb/test_xgmii_ifg_monitor.sv
`timescale 1ns/1ps
module test_xgmii_ifg_monitor;

  typedef struct {
    int    gap;
    bit    viol;
    int    cnt;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctl = 8'h00;
  logic [63:0] data = '0;

  logic [7:0]  gap_a, gap_b;
  logic        val_a, val_b, viol_a, viol_b;
  logic [15:0] cnt_a, cnt_b;

  always #2.5 clk = ~clk;

  xgmii_ifg_monitor #(.MIN_GAP(12), .DIC_EN(1'b1)) i_xgmii_ifg_monitor (
    .clk_i(clk), .rst_ni(rst_n), .xgmii_ctl_i(ctl), .xgmii_data_i(data),
    .gap_o(gap_a), .gap_valid_o(val_a), .viol_o(viol_a), .frame_cnt_o(cnt_a));

  xgmii_ifg_monitor #(.MIN_GAP(5), .DIC_EN(1'b0)) i_xgmii_ifg_monitor_strict (
    .clk_i(clk), .rst_ni(rst_n), .xgmii_ctl_i(ctl), .xgmii_data_i(data),
    .gap_o(gap_b), .gap_valid_o(val_b), .viol_o(viol_b), .frame_cnt_o(cnt_b));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  exp_t q0[$], q1[$];
  int last_gap [2];

  // reference state per instance
  int  mn [2] = '{12, 5};
  bit  dic [2] = '{1'b1, 1'b0};
  bit  inf [2];
  int  gp [2] = '{15, 15};
  int  df [2];
  int  cnt [2];

  bit [7:0] lc;
  bit [7:0] ld [8];
  int nb = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_word();
    for (int k = 0; k < 2; k++) begin
      bit ws = 0, wv = 0;
      int wg = 0;
      for (int l = 0; l < 8; l++) begin
        if (lc[l] && ld[l] == 8'hFB) begin
          if (!inf[k]) begin
            bit v = 0;
            int g = gp[k];
            if (dic[k]) begin
              if (g < mn[k]) begin
                df[k] += mn[k] - g;
                if (df[k] > 3) begin v = 1; df[k] = 3; end
              end else if (g > mn[k]) begin
                df[k] -= g - mn[k];
                if (df[k] < 0) df[k] = 0;
              end
            end else if (g < mn[k]) v = 1;
            cnt[k]++;
            ws = 1; wg = g; wv |= v;
            inf[k] = 1; gp[k] = 0;
          end
        end else if (lc[l] && ld[l] == 8'hFD) begin
          if (inf[k]) begin inf[k] = 0; gp[k] = 1; end
        end else if (lc[l] && ld[l] == 8'h07) begin
          if (!inf[k] && gp[k] < 255) gp[k]++;
        end
      end
      if (ws) begin
        exp_t e;
        e.gap = wg; e.viol = wv; e.cnt = cnt[k] & 16'hFFFF; e.req = cur_req;
        if (k == 0) q0.push_back(e); else q1.push_back(e);
      end
    end
  endtask

  task automatic put_byte(input bit c, input bit [7:0] d);
    lc[nb] = c;
    ld[nb] = d;
    nb++;
    if (nb == 8) begin
      @(posedge clk);
      #1;
      for (int l = 0; l < 8; l++) begin
        ctl[l] = lc[l];
        data[8*l +: 8] = ld[l];
      end
      model_word();
      nb = 0;
    end
  endtask

  task automatic frame(input int nd);
    put_byte(1'b1, 8'hFB);
    for (int i = 0; i < nd; i++) put_byte(1'b0, 8'h5A + i[7:0]);
    put_byte(1'b1, 8'hFD);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) put_byte(1'b1, 8'h07);
  endtask

  task automatic cmp(input int k, input logic [7:0] g, input logic v,
                     input logic [15:0] c);
    exp_t e;
    bit empty;
    empty = (k == 0) ? (q0.size() == 0) : (q1.size() == 0);
    if (empty) begin
      check(1'b0, "R9", $sformatf("inst%0d unexpected start, gap", k), g, -1);
      return;
    end
    e = (k == 0) ? q0.pop_front() : q1.pop_front();
    check(g == e.gap[7:0], e.req, $sformatf("inst%0d gap", k), g, e.gap);
    check(v == e.viol, e.req, $sformatf("inst%0d viol", k), v, e.viol);
    check(c == e.cnt[15:0], e.req, $sformatf("inst%0d frame count", k), c, e.cnt);
    last_gap[k] = e.gap;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (val_a) cmp(0, gap_a, viol_a, cnt_a);
      if (val_b) cmp(1, gap_b, viol_b, cnt_b);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run ended", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset values
    check(gap_a == 0 && gap_b == 0, "R1", "gap after reset", gap_a, 0);
    check(!val_a && !val_b && !viol_a && !viol_b, "R1", "pulses after reset",
          val_a, 0);
    check(cnt_a == 0 && cnt_b == 0, "R1", "count after reset", cnt_a, 0);

    cur_req = "R1"; frame(6);
    cur_req = "R3"; idles(11); frame(9);
    cur_req = "R5"; idles(10); frame(7);
    idles(9); frame(5);
    idles(11); frame(6);
    idles(10); frame(8);
    cur_req = "R6"; idles(13); frame(4);
    idles(20); frame(10);
    cur_req = "R5"; idles(8); frame(5);
    cur_req = "R6"; idles(14); frame(6);
    cur_req = "R4"; idles(4); frame(7);
    idles(3); frame(3);
    cur_req = "R7"; idles(300); frame(6);
    cur_req = "R8"; idles(5); put_byte(1'b1, 8'hFD); idles(10); frame(4);
    put_byte(1'b1, 8'hFB); put_byte(1'b0, 8'h11); put_byte(1'b1, 8'hFB);
    put_byte(1'b1, 8'h07); put_byte(1'b0, 8'h22); put_byte(1'b1, 8'hFD);
    idles(11); frame(3);
    cur_req = "R9"; frame(0); frame(0); frame(0); frame(0); frame(0);
    cur_req = "R2"; idles(30); frame(12);
    cur_req = "R3"; idles(15); frame(2);
    cur_req = "R10"; idles(24);
    repeat (4) @(negedge clk);
    // R10: outputs hold with no further starts
    check(gap_a == last_gap[0][7:0], "R10", "inst0 gap held", gap_a, last_gap[0]);
    check(gap_b == last_gap[1][7:0], "R10", "inst1 gap held", gap_b, last_gap[1]);
    check(q0.size() == 0, "R9", "inst0 missing starts", q0.size(), 0);
    check(q1.size() == 0, "R9", "inst1 missing starts", q1.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule